// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers interrupt causes for an Ethernet controller and drives a single level-sensitive interrupt line to the host. Single-cycle event pulses from the transmit path, the receive path and the PHY management logic set sticky status bits. A 32-bit register port lets software read those bits, mask them and clear them. The block holds two status/mask pairs. The first is a 32-bit primary pair. The second is a 16-bit management pair, and it cascades into one summary position of the primary status.

Reading either status register clears it as a side effect. The primary read keeps the stored summary bit. Two legacy offsets are steered onto the primary status and primary mask, so older drivers that use the wrong addresses still work. A reset-request register at offset 0 emits one-cycle reset pulses toward the TX and RX engines and always reads as zero. Any other aligned word inside the block acts as plain storage.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the primary status and the management status read 0. The primary mask (0x104) reads 0xFF7FFFFF, the management mask (0x114) reads 0x0000FFFF, and irq is low.
- R2: On the clock edge where an event input is high, its primary status bit is set and then stays set until a clearing read or a write. The bits are: ev_rx_host at bit 16, ev_rx_nodesc at bit 17, ev_tx_host at bit 24, ev_tx_all at bit 25. Each bit of ev_mgmt sets the same bit of the management status.
- R3: A primary mask bit of 1 blocks its status bit. irq is high when any primary status bit outside bit 23 is set with its mask bit at 0.
- R4: irq is also high whenever the management status AND NOT the management mask is nonzero. This holds whatever the stored primary bit 23 and primary mask bit 23 hold. A stored primary bit 23 on its own never raises irq.
- R5: A read of the primary status (0x100) returns the current value in the same cycle. After the edge, every bit except bit 23 is 0.
- R6: A read of the management status (0x118) returns its value. After the edge, the whole register is 0.
- R7: Offset 0x108 behaves as 0x100 and offset 0x10C behaves as 0x104, for reads, writes and the clearing side effect.
- R8: Offset 0 always reads 0. A write with bit 0 set gives a single-cycle tx_rst_pulse in the cycle after the write edge. A write with bit 1 set does the same on rx_rst_pulse.
- R9: When an event pulse and a clearing read of its status register fall in the same cycle, the event bit is set after the edge.
- R10: A write to any other aligned offset is stored, and a later read returns it unchanged.
- R11: A write to a status or mask register replaces its whole value. Event pulses in the same cycle are ORed in on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (side effects at the edge) |
| bus_addr | input | ADDR_W | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_re |
| ev_rx_host | input | 1 | Frame delivered to host |
| ev_rx_nodesc | input | 1 | No receive descriptor available |
| ev_tx_host | input | 1 | Host-to-transmit transfer done |
| ev_tx_all | input | 1 | All queued frames sent |
| ev_mgmt | input | MGMT_W | Management event pulses |
| tx_rst_pulse | output | 1 | One-cycle TX reset request |
| rx_rst_pulse | output | 1 | One-cycle RX reset request |
| irq | output | 1 | Level interrupt to host |

## Verification
Directed sequences cover the following cases:
- Reading through an alias versus the real offset.
- A stored summary bit on its own versus a live management cause.
- An event landing in the same cycle as its clearing read.

Constrained-random traffic then mixes reads, writes and alias offsets with random event bursts and random masks. It compares read data, the interrupt level and the reset pulses against a bench model after every cycle. Random masks with sparse events tell a masking fault apart from a clearing fault. Dense events tell ordering faults apart.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W  = 32;
  localparam int MGMT_W = 16;

  localparam int BIT_RX_HOST = 16;
  localparam int BIT_NO_RXD  = 17;
  localparam int BIT_SUMMARY = 23;
  localparam int BIT_TX_HOST = 24;
  localparam int BIT_TX_ALL  = 25;

  localparam int OFF_RESET       = 'h000;
  localparam int OFF_PSTAT       = 'h100;
  localparam int OFF_PMASK       = 'h104;
  localparam int OFF_PSTAT_ALIAS = 'h108;
  localparam int OFF_PMASK_ALIAS = 'h10C;
  localparam int OFF_MMASK       = 'h114;
  localparam int OFF_MSTAT       = 'h118;

  localparam logic [REG_W-1:0]  PMASK_RST = 32'hFF7F_FFFF;
  localparam logic [MGMT_W-1:0] MMASK_RST = 16'hFFFF;
  localparam logic [REG_W-1:0]  PKEEP     = REG_W'(1) << BIT_SUMMARY;

  typedef enum logic [2:0] {
    SEL_RESET, SEL_PSTAT, SEL_PMASK, SEL_MSTAT, SEL_MMASK, SEL_SCRATCH
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    sel = SEL_SCRATCH;
    if (addr == ADDR_W'(OFF_RESET))                                           sel = SEL_RESET;
    else if (addr == ADDR_W'(OFF_PSTAT) || addr == ADDR_W'(OFF_PSTAT_ALIAS))  sel = SEL_PSTAT;
    else if (addr == ADDR_W'(OFF_PMASK) || addr == ADDR_W'(OFF_PMASK_ALIAS))  sel = SEL_PMASK;
    else if (addr == ADDR_W'(OFF_MSTAT))                                      sel = SEL_MSTAT;
    else if (addr == ADDR_W'(OFF_MMASK))                                      sel = SEL_MMASK;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] KEEP    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         clr_en,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] stat_d;
  logic         upd;

  always_comb begin
    stat_d = stat_q;
    if (wr_en)       stat_d = wr_data;
    else if (clr_en) stat_d = stat_q & KEEP;
    stat_d = stat_d | set_vec;
    upd    = wr_en | clr_en | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat_q <= RST_VAL;
    else if (upd) stat_q <= stat_d;
  end
endmodule

// File: rtl/irq_level_merge.sv
module irq_level_merge #(
  parameter int P_W     = 32,
  parameter int M_W     = 16,
  parameter int SUM_BIT = 23
) (
  input  logic [P_W-1:0] pstat,
  input  logic [P_W-1:0] pmask,
  input  logic [M_W-1:0] mstat,
  input  logic [M_W-1:0] mmask,
  output logic           irq
);
  localparam logic [P_W-1:0] SUM_ONLY = P_W'(1) << SUM_BIT;
  logic [P_W-1:0] p_eff;
  logic           m_any;

  always_comb begin
    m_any = |(mstat & ~mmask);
    p_eff = pstat & ~pmask & ~SUM_ONLY;
    if (m_any) p_eff = p_eff | SUM_ONLY;
    irq = |p_eff;
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              ev_rx_host,
  input  logic              ev_rx_nodesc,
  input  logic              ev_tx_host,
  input  logic              ev_tx_all,
  input  logic [MGMT_W-1:0] ev_mgmt,
  output logic              tx_rst_pulse,
  output logic              rx_rst_pulse,
  output logic              irq
);
  localparam int WORDS = 2 ** (ADDR_W - 2);

  reg_sel_e          sel;
  logic [REG_W-1:0]  pstat_q, pmask_q, pmask_d, p_set;
  logic [MGMT_W-1:0] mstat_q, mmask_q, mmask_d;
  logic              rd_clr, p_wr, m_wr, pm_wr, mm_wr, scr_wr, rst_wr;
  logic              tx_pulse_d, rx_pulse_d;
  logic [REG_W-1:0]  scratch [WORDS];

  irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

  always_comb begin
    rd_clr = bus_re & ~bus_we;
    p_wr   = bus_we & (sel == SEL_PSTAT);
    m_wr   = bus_we & (sel == SEL_MSTAT);
    pm_wr  = bus_we & (sel == SEL_PMASK);
    mm_wr  = bus_we & (sel == SEL_MMASK);
    scr_wr = bus_we & (sel == SEL_SCRATCH);
    rst_wr = bus_we & (sel == SEL_RESET);
    p_set  = '0;
    p_set[BIT_RX_HOST] = ev_rx_host;
    p_set[BIT_NO_RXD]  = ev_rx_nodesc;
    p_set[BIT_TX_HOST] = ev_tx_host;
    p_set[BIT_TX_ALL]  = ev_tx_all;
  end

  irq_status_reg #(.W(REG_W), .RST_VAL('0), .KEEP(PKEEP)) u_pstat (
    .clk(clk), .rst_n(rst_n), .wr_en(p_wr), .wr_data(bus_wdata),
    .clr_en(rd_clr && sel == SEL_PSTAT), .set_vec(p_set), .stat_q(pstat_q));

  irq_status_reg #(.W(MGMT_W), .RST_VAL('0), .KEEP('0)) u_mstat (
    .clk(clk), .rst_n(rst_n), .wr_en(m_wr), .wr_data(bus_wdata[MGMT_W-1:0]),
    .clr_en(rd_clr && sel == SEL_MSTAT), .set_vec(ev_mgmt), .stat_q(mstat_q));

  always_comb begin
    pmask_d    = pm_wr ? bus_wdata : pmask_q;
    mmask_d    = mm_wr ? bus_wdata[MGMT_W-1:0] : mmask_q;
    tx_pulse_d = rst_wr & bus_wdata[0];
    rx_pulse_d = rst_wr & bus_wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmask_q      <= PMASK_RST;
      mmask_q      <= MMASK_RST;
      tx_rst_pulse <= 1'b0;
      rx_rst_pulse <= 1'b0;
    end else begin
      if (pm_wr) pmask_q <= pmask_d;
      if (mm_wr) mmask_q <= mmask_d;
      tx_rst_pulse <= tx_pulse_d;
      rx_rst_pulse <= rx_pulse_d;
    end
  end

  always_ff @(posedge clk) begin
    if (scr_wr) scratch[bus_addr[ADDR_W-1:2]] <= bus_wdata;
  end

  always_comb begin
    unique case (sel)
      SEL_RESET: bus_rdata = '0;
      SEL_PSTAT: bus_rdata = pstat_q;
      SEL_PMASK: bus_rdata = pmask_q;
      SEL_MSTAT: bus_rdata = REG_W'(mstat_q);
      SEL_MMASK: bus_rdata = REG_W'(mmask_q);
      default:   bus_rdata = scratch[bus_addr[ADDR_W-1:2]];
    endcase
  end

  irq_level_merge #(.P_W(REG_W), .M_W(MGMT_W), .SUM_BIT(BIT_SUMMARY)) u_merge (
    .pstat(pstat_q), .pmask(pmask_q), .mstat(mstat_q), .mmask(mmask_q), .irq(irq));
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wd0,
  input logic              wd1,
  input logic [31:0]       bus_rdata,
  input logic              ev_rx_host,
  input logic              ev_any_p,
  input logic              ev_tx_all,
  input logic              ev_any_m,
  input logic [31:0]       pstat_q,
  input logic [31:0]       pmask_q,
  input logic [15:0]       mstat_q,
  input logic [15:0]       mmask_q,
  input logic              tx_rst_pulse,
  input logic              rx_rst_pulse,
  input logic              irq
);
  logic rd_p;
  assign rd_p = bus_re && !bus_we && (bus_addr == ADDR_W'('h100) || bus_addr == ADDR_W'('h108));

  // R2
  ev_rx_sets_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_rx_host |=> pstat_q[16]);
  // R9
  ev_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) (rd_p && ev_tx_all) |=> pstat_q[25]);
  // R5
  pstat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_p && !ev_any_p) |=> ((pstat_q & 32'hFF7F_FFFF) == 32'h0));
  // R6
  mstat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !bus_we && bus_addr == ADDR_W'('h118) && !ev_any_m) |=> (mstat_q == 16'h0));
  // R4
  summary_irq_chk: assert property (@(posedge clk) disable iff (!rst_n) (|(mstat_q & ~mmask_q)) |-> irq);
  // R3
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> ((pstat_q & ~pmask_q & 32'hFF7F_FFFF) == 32'h0));
  // R8
  rst_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == '0) |-> (bus_rdata == 32'h0));
  // R8
  tx_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_pulse |-> $past(bus_we && bus_addr == '0 && wd0));
  // R8
  rx_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_pulse |-> $past(bus_we && bus_addr == '0 && wd1));
endmodule

bind irq_status_agg irq_agg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
  .wd0(bus_wdata[0]), .wd1(bus_wdata[1]), .bus_rdata(bus_rdata),
  .ev_rx_host(ev_rx_host), .ev_any_p(ev_rx_host | ev_rx_nodesc | ev_tx_host | ev_tx_all),
  .ev_tx_all(ev_tx_all), .ev_any_m(|ev_mgmt),
  .pstat_q(pstat_q), .pmask_q(pmask_q), .mstat_q(mstat_q), .mmask_q(mmask_q),
  .tx_rst_pulse(tx_rst_pulse), .rx_rst_pulse(rx_rst_pulse), .irq(irq));

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;
  localparam int AW = 9;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 0, bus_re = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ev_rx_host = 0, ev_rx_nodesc = 0, ev_tx_host = 0, ev_tx_all = 0;
  logic [15:0] ev_mgmt = '0;
  logic tx_rst_pulse, rx_rst_pulse, irq;
  int nchk = 0, nerr = 0;
  bit done = 0;

  logic [31:0] m_pstat, m_pmask, m_scr [8];
  logic [15:0] m_mstat, m_mmask;

  always #2 clk = ~clk;

  irq_status_agg #(.ADDR_W(AW)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] canon(input logic [8:0] a);
    if (a == 9'h108) return 9'h100;
    if (a == 9'h10C) return 9'h104;
    return a;
  endfunction

  function automatic logic [31:0] model_read(input logic [8:0] a0);
    logic [8:0] a = canon(a0);
    case (a)
      9'h000:  return 32'h0;
      9'h100:  return m_pstat;
      9'h104:  return m_pmask;
      9'h114:  return {16'h0, m_mmask};
      9'h118:  return {16'h0, m_mstat};
      default: return m_scr[a[4:2]];
    endcase
  endfunction

  function automatic bit model_irq();
    return ((m_pstat & ~m_pmask & 32'hFF7F_FFFF) != 0) || ((m_mstat & ~m_mmask) != 0);
  endfunction

  // pe: [0]=bit16 [1]=bit17 [2]=bit24 [3]=bit25
  task automatic step(input bit we, input bit re, input logic [8:0] a, input logic [31:0] wd,
                      input logic [3:0] pe, input logic [15:0] me, input string tag);
    logic [8:0] c;
    logic [31:0] ps;
    logic [15:0] ms;
    bit etx, erx;
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd;
    {ev_tx_all, ev_tx_host, ev_rx_nodesc, ev_rx_host} = pe;
    ev_mgmt = me;
    #1;
    if (re && !we) check(tag, bus_rdata, model_read(a));
    c = canon(a);
    ps = m_pstat; ms = m_mstat;
    etx = we && c == 9'h000 && wd[0];
    erx = we && c == 9'h000 && wd[1];
    if (we) begin
      case (c)
        9'h100: ps = wd;
        9'h104: m_pmask = wd;
        9'h114: m_mmask = wd[15:0];
        9'h118: ms = wd[15:0];
        9'h000: ;
        default: m_scr[c[4:2]] = wd;
      endcase
    end else if (re) begin
      if (c == 9'h100) ps = ps & 32'h0080_0000;
      if (c == 9'h118) ms = '0;
    end
    ps = ps | {6'b0, pe[3], pe[2], 6'b0, pe[1], pe[0], 16'b0};
    ms = ms | me;
    @(posedge clk); @(negedge clk);
    bus_we = 0; bus_re = 0; ev_mgmt = '0;
    {ev_tx_all, ev_tx_host, ev_rx_nodesc, ev_rx_host} = '0;
    m_pstat = ps; m_mstat = ms;
    check("R3 R4 irq level", {31'b0, irq}, {31'b0, model_irq()});
    check("R8 tx pulse", {31'b0, tx_rst_pulse}, {31'b0, etx});
    check("R8 rx pulse", {31'b0, rx_rst_pulse}, {31'b0, erx});
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input string t);
    step(1, 0, a, d, '0, '0, t);
  endtask
  task automatic rd(input logic [8:0] a, input string t);
    step(0, 1, a, '0, '0, '0, t);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [8:0] addrs [15];
    void'($urandom(32'h5EED_0042));
    m_pstat = 0; m_mstat = 0; m_pmask = 32'hFF7F_FFFF; m_mmask = 16'hFFFF;
    addrs = '{9'h000, 9'h100, 9'h104, 9'h108, 9'h10C, 9'h114, 9'h118,
              9'h020, 9'h024, 9'h028, 9'h02C, 9'h030, 9'h034, 9'h038, 9'h03C};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(9'h104, "R1 primary mask reset");
    rd(9'h114, "R1 mgmt mask reset");
    rd(9'h100, "R1 primary status reset");
    rd(9'h118, "R1 mgmt status reset");
    // R10 scratch fill and readback
    for (int k = 0; k < 8; k++) wr(9'h020 + 9'(4 * k), $urandom, "R10 fill");
    for (int k = 0; k < 8; k++) rd(9'h020 + 9'(4 * k), "R10 scratch readback");
    // R8 reset register
    wr(9'h000, 32'h3, "R8 reset write");
    rd(9'h000, "R8 reset reads zero");
    // R2 R3 R7 unmask rx, event, alias read
    wr(9'h10C, 32'hFFFE_FFFF, "R7 mask via alias");
    rd(9'h104, "R7 mask via alias readback");
    step(0, 0, 9'h0, 0, 4'b0001, '0, "R2 rx event");
    check("R3 unmasked event raises irq", {31'b0, irq}, 32'h1);
    rd(9'h108, "R7 status read via alias");
    rd(9'h100, "R5 status cleared after alias read");
    // R9 event vs clearing read
    step(0, 1, 9'h100, 0, 4'b1000, '0, "R9 read with event");
    rd(9'h100, "R9 event kept after clearing read");
    // R4 summary path
    wr(9'h104, 32'hFFFF_FFFF, "R4 mask all primary");
    wr(9'h114, 32'h0000_FFFE, "R4 unmask mgmt bit 0");
    step(0, 0, 9'h0, 0, '0, 16'h0001, "R4 mgmt event");
    check("R4 mgmt raises irq", {31'b0, irq}, 32'h1);
    rd(9'h118, "R6 mgmt status read");
    rd(9'h118, "R6 mgmt status cleared");
    wr(9'h104, 32'h0, "R4 unmask all primary");
    wr(9'h100, 32'h0080_0000, "R4 stored summary only");
    check("R4 stored bit 23 alone no irq", {31'b0, irq}, 32'h0);
    wr(9'h100, 32'hFFFF_FFFF, "R11 status full write");
    rd(9'h100, "R11 status write readback");
    rd(9'h100, "R5 keeps only bit 23");
    // random traffic
    for (int i = 0; i < 600; i++) begin
      int unsigned op = $urandom % 4;
      logic [8:0] a = addrs[$urandom % 15];
      logic [3:0] pe = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
      logic [15:0] me = (($urandom % 4) == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
      logic [31:0] d = $urandom;
      if (a == 9'h104 || a == 9'h10C || a == 9'h114) d = d | $urandom;
      step(op == 0, op != 0 && op != 3, a, d, pe, me, "R2 R5 R6 R7 R9 R10 R11 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule